// File: doc/BRIEF.md
# Grouped Multichannel Sampling Sequencer

This block paces the conversions of a multichannel acquisition front end. It gives one convert strobe per conversion, together with the index of the channel to convert, and it shows through a busy flag whether a run is in progress. The sample period comes from a programmable divisor applied to the 20 MHz master clock. Divisors below a floor of 80 are raised to that floor.

The block has two modes. In continuous mode it sweeps the selected channel range again and again at a constant rate. In grouped mode it sweeps the range a programmed number of times in a burst. It then holds for a settle time and a group interval, and starts the next burst. In grouped mode an external clock can launch each burst instead. In that case the interval is skipped, and external edges that arrive before the start or during a burst have no effect.

The channel range, divisor, loop count, settle time and interval are expected to stay fixed while busy is high.

Top module: `grp_sample_seq`

## Requirements
- R1: While reset is high and afterwards until a start, busy and the strobe are 0 and the channel output equals the configured first channel.
- R2: A start pulse sampled with enable high while idle raises busy. In internal pacing, the first strobe appears in the cycle right after the edge that sampled the start, with the channel equal to the first channel.
- R3: In continuous mode, consecutive strobes are exactly D cycles apart, where D is the divisor. The channel steps from first to last and wraps back to first with no pause.
- R4: A divisor below 80 behaves as 80.
- R5: In grouped mode, one group is the channel range swept L times, so N×L strobes D cycles apart, where N = last − first + 1. A loop count of 0 acts as 1.
- R6: With internal pacing, the first strobe of the next group comes 1 + C + 20×G cycles after the last strobe of the previous group. C is the settle count in master cycles and G is the interval in microseconds of 20 cycles each.
- R7: With external launch selected, no strobe appears after the start until a rising edge of the external clock. The first strobe of that group appears in the third cycle after the clock edge that first samples the input high.
- R8: External rising edges that occur before the start, or while a group is sweeping or settling, launch nothing.
- R9: With enable low, busy and the strobe are 0 from the next cycle on, the channel returns to the first channel, and a later start begins a fresh sweep.
- R10: A start pulse while busy has no effect on the strobe timing or the channel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low forces idle |
| start | input | 1 | Start pulse, taken while idle |
| grouped | input | 1 | 1 = grouped mode, 0 = continuous |
| ext_launch | input | 1 | 1 = external clock launches each group (grouped only) |
| ext_clk | input | 1 | External launch clock, asynchronous |
| divisor | input | 32 | Sample period in master cycles |
| first_ch | input | 5 | First channel of the sweep |
| last_ch | input | 5 | Last channel of the sweep (not below first) |
| loops | input | 16 | Sweeps per group |
| settle_cycles | input | 16 | Master cycles held after the last strobe of a group |
| interval_us | input | 19 | Group interval in microseconds |
| cnv_strobe | output | 1 | One-cycle convert strobe |
| chan | output | 5 | Channel to convert while the strobe is high |
| busy | output | 1 | A run is in progress |

## Verification
An external rising edge and an ongoing group can coincide. The bench provokes this by raising the external clock in the middle of a burst. It judges the result by counting the strobes that follow: a correct design keeps exactly one group's worth and then waits for a fresh edge. A start pulse can also coincide with a running continuous sweep. Here the bench checks that the spacing and channel order of the following strobes are unchanged. Group boundaries are judged by comparing the cycle stamps of the last strobe of one group and the first strobe of the next against 1 + C + 20×G.

// File: rtl/gss_pkg.sv
package gss_pkg;

    localparam int MASTER_HZ = 20_000_000;
    localparam int US_TICKS  = MASTER_HZ / 1_000_000;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_HOLD,
        SQ_WAIT_EXT
    } seq_state_e;

    typedef enum logic [1:0] {
        HT_OFF,
        HT_SETTLE,
        HT_GAP
    } hold_phase_e;

    function automatic logic is_active(input seq_state_e s);
        return s != SQ_IDLE;
    endfunction

endpackage

// File: rtl/gss_pacer.sv
module gss_pacer #(
    parameter int DIV_W   = 32,
    parameter int MIN_DIV = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt_q;

    assign div_eff = (divisor < FLOOR) ? FLOOR : divisor;
    assign tick    = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= div_eff - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/gss_sweep.sv
module gss_sweep #(
    parameter int CH_W   = 5,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              adv,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    input  logic [LOOP_W-1:0] loops,
    output logic [CH_W-1:0]   chan,
    output logic              group_end
);
    logic [CH_W-1:0]   ch_q;
    logic [LOOP_W-1:0] lp_q;
    logic [LOOP_W-1:0] lp_last;
    logic              at_last_ch;

    assign lp_last    = (loops == '0) ? '0 : loops - 1'b1;
    assign at_last_ch = (ch_q == last_ch);
    assign group_end  = at_last_ch && (lp_q == lp_last);
    assign chan       = ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q <= '0;
            lp_q <= '0;
        end else if (clear) begin
            ch_q <= first_ch;
            lp_q <= '0;
        end else if (adv) begin
            if (at_last_ch) begin
                ch_q <= first_ch;
                lp_q <= (lp_q == lp_last) ? '0 : lp_q + 1'b1;
            end else begin
                ch_q <= ch_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gss_hold_timer.sv
module gss_hold_timer
    import gss_pkg::*;
#(
    parameter int SETTLE_W     = 16,
    parameter int GAP_W        = 19,
    parameter int TICKS_PER_US = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                abort,
    input  logic                load,
    input  logic                use_gap,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GAP_W-1:0]    interval_us,
    output logic                zero_len,
    output logic                expire
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICKS_PER_US - 1);

    hold_phase_e         phase_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [GAP_W-1:0]    us_q;
    logic [PRE_W-1:0]    pre_q;
    logic                gap_q;
    logic                gap_now;
    logic                gap_wanted;

    assign gap_now    = use_gap && (interval_us != '0);
    assign gap_wanted = gap_q && (interval_us != '0);
    assign zero_len   = (settle_cycles == '0) && !gap_now;
    assign expire     = ((phase_q == HT_SETTLE) && (settle_q == '0) && !gap_wanted)
                     || ((phase_q == HT_GAP) && (pre_q == '0) && (us_q == '0));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase_q  <= HT_OFF;
            settle_q <= '0;
            us_q     <= '0;
            pre_q    <= '0;
            gap_q    <= 1'b0;
        end else if (load) begin
            gap_q <= use_gap;
            if (settle_cycles != '0) begin
                phase_q  <= HT_SETTLE;
                settle_q <= settle_cycles - 1'b1;
            end else if (gap_now) begin
                phase_q <= HT_GAP;
                us_q    <= interval_us - 1'b1;
                pre_q   <= PRE_TOP;
            end else begin
                phase_q <= HT_OFF;
            end
        end else begin
            case (phase_q)
                HT_SETTLE: begin
                    if (settle_q != '0) begin
                        settle_q <= settle_q - 1'b1;
                    end else if (gap_wanted) begin
                        phase_q <= HT_GAP;
                        us_q    <= interval_us - 1'b1;
                        pre_q   <= PRE_TOP;
                    end else begin
                        phase_q <= HT_OFF;
                    end
                end
                HT_GAP: begin
                    if (pre_q != '0) begin
                        pre_q <= pre_q - 1'b1;
                    end else if (us_q != '0) begin
                        us_q  <= us_q - 1'b1;
                        pre_q <= PRE_TOP;
                    end else begin
                        phase_q <= HT_OFF;
                    end
                end
                default: phase_q <= HT_OFF;
            endcase
        end
    end
endmodule

// File: rtl/grp_sample_seq.sv
module grp_sample_seq
    import gss_pkg::*;
#(
    parameter int DIV_W        = 32,
    parameter int CH_W         = 5,
    parameter int LOOP_W       = 16,
    parameter int SETTLE_W     = 16,
    parameter int GAP_W        = 19,
    parameter int MIN_DIV      = 80,
    parameter int TICKS_PER_US = gss_pkg::US_TICKS,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                start,
    input  logic                grouped,
    input  logic                ext_launch,
    input  logic                ext_clk,
    input  logic [DIV_W-1:0]    divisor,
    input  logic [CH_W-1:0]     first_ch,
    input  logic [CH_W-1:0]     last_ch,
    input  logic [LOOP_W-1:0]   loops,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GAP_W-1:0]    interval_us,
    output logic                cnv_strobe,
    output logic [CH_W-1:0]     chan,
    output logic                busy
);
    seq_state_e state_q, state_d;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev_q;
    logic                   ext_rise;
    logic                   tick;
    logic                   group_end;
    logic                   ext_mode;
    logic                   last_of_group;
    logic                   restart;
    logic                   load_hold;
    logic                   zero_len;
    logic                   expire;

    // external clock synchronizer, depth chosen by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_clk;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ext_prev_q <= 1'b0;
        else     ext_prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise      = sync_q[SYNC_STAGES-1] && !ext_prev_q;
    assign ext_mode      = grouped && ext_launch;
    assign cnv_strobe    = enable && (state_q == SQ_RUN) && tick;
    assign last_of_group = cnv_strobe && grouped && group_end;
    assign busy          = is_active(state_q);

    gss_pacer #(
        .DIV_W   (DIV_W),
        .MIN_DIV (MIN_DIV)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == SQ_RUN),
        .restart (restart),
        .divisor (divisor),
        .tick    (tick)
    );

    gss_sweep #(
        .CH_W   (CH_W),
        .LOOP_W (LOOP_W)
    ) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .clear     (!enable || (state_q == SQ_IDLE)),
        .adv       (cnv_strobe),
        .first_ch  (first_ch),
        .last_ch   (last_ch),
        .loops     (loops),
        .chan      (chan),
        .group_end (group_end)
    );

    gss_hold_timer #(
        .SETTLE_W     (SETTLE_W),
        .GAP_W        (GAP_W),
        .TICKS_PER_US (TICKS_PER_US)
    ) u_hold (
        .clk           (clk),
        .rst           (rst),
        .abort         (!enable),
        .load          (load_hold),
        .use_gap       (!ext_mode),
        .settle_cycles (settle_cycles),
        .interval_us   (interval_us),
        .zero_len      (zero_len),
        .expire        (expire)
    );

    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        load_hold = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (enable && start) begin
                    state_d = ext_mode ? SQ_WAIT_EXT : SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (last_of_group) begin
                    if (!zero_len) begin
                        load_hold = 1'b1;
                        state_d   = SQ_HOLD;
                    end else if (ext_mode) begin
                        state_d = SQ_WAIT_EXT;
                    end else begin
                        restart = 1'b1;
                    end
                end
            end
            SQ_HOLD: begin
                if (expire) begin
                    state_d = ext_mode ? SQ_WAIT_EXT : SQ_RUN;
                end
            end
            SQ_WAIT_EXT: begin
                if (ext_rise) begin
                    state_d = SQ_RUN;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (!enable) begin
            state_d = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/gss_seq_chk.sv
module gss_seq_chk #(
    parameter int DIV_W   = 32,
    parameter int CH_W    = 5,
    parameter int MIN_DIV = 80
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             start,
    input logic             grouped,
    input logic             ext_launch,
    input logic [DIV_W-1:0] divisor,
    input logic [CH_W-1:0]  first_ch,
    input logic [CH_W-1:0]  last_ch,
    input logic             cnv_strobe,
    input logic [CH_W-1:0]  chan,
    input logic             busy
);
    logic [DIV_W-1:0] since_q;
    logic             seen_q;
    logic [DIV_W-1:0] eff_div;

    assign eff_div = (divisor < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : divisor;

    always_ff @(posedge clk) begin
        if (rst || !busy || grouped) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cnv_strobe) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cnv_strobe);

    p_first_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && start && !busy && !(grouped && ext_launch))
        |=> (!enable || (busy && cnv_strobe)));

    p_even_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (cnv_strobe && seen_q && !grouped) |-> (since_q == eff_div - 1'b1));

    p_chan_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        cnv_strobe |-> ((chan >= first_ch) && (chan <= last_ch)));

    p_disable_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !cnv_strobe));
endmodule

bind grp_sample_seq gss_seq_chk #(
    .DIV_W   (DIV_W),
    .CH_W    (CH_W),
    .MIN_DIV (MIN_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start      (start),
    .grouped    (grouped),
    .ext_launch (ext_launch),
    .divisor    (divisor),
    .first_ch   (first_ch),
    .last_ch    (last_ch),
    .cnv_strobe (cnv_strobe),
    .chan       (chan),
    .busy       (busy)
);

// File: tb/tb_grp_sample_seq.sv
module tb_grp_sample_seq;

    typedef struct packed {
        logic        grp;
        logic [31:0] div;
        logic [4:0]  fch;
        logic [4:0]  lch;
        logic [15:0] lps;
        logic [15:0] stl;
        logic [18:0] gap;
        logic [31:0] exp_step;
        logic [31:0] exp_ggap;
    } vec_t;

    // stimulus with hand-computed spacing: step = max(div,80); group gap = 1+stl+20*gap
    localparam vec_t VECS [5] = '{
        '{1'b0, 32'd100, 5'd2, 5'd4, 16'd1, 16'd0, 19'd0, 32'd100, 32'd0},
        '{1'b0, 32'd10,  5'd0, 5'd0, 16'd1, 16'd0, 19'd0, 32'd80,  32'd0},
        '{1'b1, 32'd80,  5'd0, 5'd1, 16'd2, 16'd5, 19'd2, 32'd80,  32'd46},
        '{1'b1, 32'd90,  5'd3, 5'd5, 16'd1, 16'd0, 19'd0, 32'd90,  32'd1},
        '{1'b1, 32'd85,  5'd1, 5'd2, 16'd0, 16'd3, 19'd1, 32'd85,  32'd24}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic        grouped = 1'b0;
    logic        ext_launch = 1'b0;
    logic        ext_clk = 1'b0;
    logic [31:0] divisor = 32'd100;
    logic [4:0]  first_ch = '0;
    logic [4:0]  last_ch = '0;
    logic [15:0] loops = 16'd1;
    logic [15:0] settle_cycles = '0;
    logic [18:0] interval_us = '0;
    logic        cnv_strobe;
    logic [4:0]  chan;
    logic        busy;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int nlog = 0;
    logic clr_log = 1'b0;
    int log_t [64];
    int log_c [64];

    always #5 clk = ~clk;

    grp_sample_seq dut (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .start         (start),
        .grouped       (grouped),
        .ext_launch    (ext_launch),
        .ext_clk       (ext_clk),
        .divisor       (divisor),
        .first_ch      (first_ch),
        .last_ch       (last_ch),
        .loops         (loops),
        .settle_cycles (settle_cycles),
        .interval_us   (interval_us),
        .cnv_strobe    (cnv_strobe),
        .chan          (chan),
        .busy          (busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (clr_log) begin
            nlog <= 0;
        end else if (cnv_strobe && nlog < 64) begin
            log_t[nlog] <= cyc;
            log_c[nlog] <= int'(chan);
            nlog <= nlog + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_log();
        @(negedge clk);
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
    endtask

    // pulse start; returns the cycle stamp of the edge that samples it
    task automatic pulse_start(output int ts);
        @(negedge clk);
        start = 1'b1;
        ts = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 5000 && nlog < n; i++) @(negedge clk);
    endtask

    initial begin
        int ts;
        int t_ext;
        int t_ext2;

        ticks(3);
        check(!busy && !cnv_strobe && chan == 5'd0, "R1 reset", int'({busy, cnv_strobe, chan}), 0);
        rst = 1'b0;
        ticks(2);
        check(!busy && !cnv_strobe && chan == 5'd0, "R1 after reset", int'({busy, cnv_strobe, chan}), 0);

        // table walk
        for (int v = 0; v < 5; v++) begin
            int n_ch;
            int g_len;
            int dt;
            int ec;
            int eg;
            n_ch = int'(VECS[v].lch) - int'(VECS[v].fch) + 1;
            g_len = n_ch * ((VECS[v].lps == 0) ? 1 : int'(VECS[v].lps));
            @(negedge clk);
            grouped = VECS[v].grp;
            ext_launch = 1'b0;
            divisor = VECS[v].div;
            first_ch = VECS[v].fch;
            last_ch = VECS[v].lch;
            loops = VECS[v].lps;
            settle_cycles = VECS[v].stl;
            interval_us = VECS[v].gap;
            enable = 1'b1;
            clear_log();
            check(chan == VECS[v].fch, "R1 idle chan", int'(chan), int'(VECS[v].fch));
            pulse_start(ts);
            check(busy, "R2 busy", int'(busy), 1);
            wait_log(8);
            check(nlog >= 8, "R3 strobe count", nlog, 8);
            check(log_t[0] == ts, "R2 first strobe", log_t[0], ts);
            for (int k = 0; k < 8; k++) begin
                ec = int'(VECS[v].fch) + (k % n_ch);
                check(log_c[k] == ec, VECS[v].grp ? "R5 chan" : "R3 chan", log_c[k], ec);
                if (k > 0) begin
                    dt = log_t[k] - log_t[k-1];
                    if (VECS[v].grp && (k % g_len == 0)) begin
                        eg = int'(VECS[v].exp_ggap);
                        check(dt == eg, "R6 group gap", dt, eg);
                    end else begin
                        eg = int'(VECS[v].exp_step);
                        check(dt == eg, (VECS[v].div < 80) ? "R4 floor" :
                              (VECS[v].grp ? "R5 step" : "R3 step"), dt, eg);
                    end
                end
            end
            @(negedge clk);
            enable = 1'b0;
            ticks(3);
        end

        // R7 / R8: external launch
        @(negedge clk);
        grouped = 1'b1;
        ext_launch = 1'b1;
        divisor = 32'd80;
        first_ch = 5'd0;
        last_ch = 5'd1;
        loops = 16'd1;
        settle_cycles = 16'd2;
        interval_us = 19'd3;
        enable = 1'b1;
        ext_clk = 1'b1;
        ticks(5);
        ext_clk = 1'b0;
        ticks(5);
        clear_log();
        pulse_start(ts);
        ticks(200);
        check(nlog == 0, "R8 pre-start edge ignored", nlog, 0);
        check(busy, "R7 waits busy", int'(busy), 1);
        @(negedge clk);
        ext_clk = 1'b1;
        t_ext = cyc + 3;
        ticks(40);
        ext_clk = 1'b0;
        ticks(5);
        ext_clk = 1'b1;
        ticks(300);
        check(nlog == 2, "R8 mid-group edge ignored", nlog, 2);
        check(log_t[0] == t_ext, "R7 launch latency", log_t[0], t_ext);
        check(log_t[1] - log_t[0] == 80, "R7 paced group", log_t[1] - log_t[0], 80);
        ext_clk = 1'b0;
        ticks(5);
        ext_clk = 1'b1;
        t_ext2 = cyc + 3;
        ticks(100);
        check(nlog == 4, "R7 second group", nlog, 4);
        check(log_t[2] == t_ext2, "R7 second launch", log_t[2], t_ext2);
        check(log_c[2] == 0, "R7 second chan", log_c[2], 0);
        enable = 1'b0;
        ext_clk = 1'b0;
        ticks(3);

        // R9: disable mid-run in grouped mode, then restart
        @(negedge clk);
        ext_launch = 1'b0;
        divisor = 32'd100;
        first_ch = 5'd3;
        last_ch = 5'd6;
        loops = 16'd2;
        settle_cycles = 16'd0;
        interval_us = 19'd0;
        enable = 1'b1;
        clear_log();
        pulse_start(ts);
        ticks(150);
        enable = 1'b0;
        @(negedge clk);
        check(!busy && !cnv_strobe, "R9 idle after disable", int'({busy, cnv_strobe}), 0);
        check(chan == 5'd3, "R9 chan reset", int'(chan), 3);
        ticks(300);
        check(nlog == 2, "R9 no strobes while disabled", nlog, 2);
        enable = 1'b1;
        clear_log();
        pulse_start(ts);
        wait_log(9);
        check(log_c[0] == 3 && log_c[1] == 4, "R9 fresh sweep", log_c[1], 4);
        check(log_t[8] - log_t[7] == 1, "R9 fresh loop count", log_t[8] - log_t[7], 1);
        @(negedge clk);
        enable = 1'b0;
        ticks(3);

        // R10: start while busy
        @(negedge clk);
        grouped = 1'b0;
        divisor = 32'd80;
        first_ch = 5'd0;
        last_ch = 5'd3;
        enable = 1'b1;
        clear_log();
        pulse_start(ts);
        ticks(30);
        pulse_start(ts);
        wait_log(3);
        check(log_t[1] - log_t[0] == 80, "R10 spacing kept", log_t[1] - log_t[0], 80);
        check(log_c[1] == 1 && log_c[2] == 2, "R10 order kept", log_c[2], 2);
        @(negedge clk);
        enable = 1'b0;
        ticks(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule